// File: doc/BRIEF.md
# Processor Status Word Controller

This block keeps the eight-bit status word of a small microcontroller core. Each cycle it combines three sources of change into a single register. The first is a software write, issued when an instruction names the status register as its destination. The second is a set of result flags from the ALU, each with its own update enable. The third is a set of power-state events: the watchdog-clear instruction, the sleep instruction and the watchdog timeout. Power-up is the block's reset.

A software write is only partly honoured. The two power-status bits cannot be written by software at all. If the same instruction also updates any of the zero, digit-carry or carry flags, the written data is dropped for all three flag positions. Flags whose enable is set take the ALU value, and the other flags keep their old value. Instructions that change single bits, swap nibbles or move the accumulator to the register raise no flag enables, so they write every writable bit directly. The block also drives the bank-select bit that the data-memory address path uses for direct addressing.

Bit layout, from bit 7 down to bit 0: extended indirect bank (`IRB`), upper bank bit (`BKH`), lower bank bit (`BKL`), timeout flag (`TOF`), power-down flag (`PDF`), zero (`ZF`), digit carry (`DCF`), carry (`CF`).

Top module: `psw_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the status word reads 8'h18: bits 7:5 are 0, `TOF` (bit 4) and `PDF` (bit 3) are 1, and the flags in bits 2:0 are 0.
- R2: A write with all three flag enables low loads bits 7:5 and bits 2:0 from `wr_data` on the next clock edge.
- R3: Software writes never change bits 4 and 3. These bits change only in a cycle in which a power event strobe is high.
- R4: If a write occurs while at least one flag enable is high, `wr_data[2:0]` is ignored. Each enabled flag takes its ALU value and each flag that is not enabled keeps its value. Bits 7:5 are still written.
- R5: A flag enable without a write updates only that flag (bit 2 zero, bit 1 digit carry, bit 0 carry) and leaves all other bits unchanged.
- R6: A clear-file write (`wr_data` = 0, `upd_z` = 1, `alu_z` = 1, other enables low) gives the pattern 000u u1uu, where u means the bit keeps its old value.
- R7: `ev_wdt_to` clears `TOF`. `ev_clrwdt` or `ev_sleep` sets it. When a timeout and a set event occur in the same cycle, the timeout wins.
- R8: `ev_sleep` clears `PDF` and `ev_clrwdt` sets it. When both occur in the same cycle, sleep wins. The timeout does not touch `PDF`.
- R9: `bank_sel` equals bit 5 of the status word: 0 selects data addresses 00h-7Fh and 1 selects 80h-FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| wr_en | input | 1 | Instruction writes the status register |
| wr_data | input | 8 | Data written by the instruction |
| upd_z | input | 1 | Instruction updates the zero flag |
| upd_dc | input | 1 | Instruction updates the digit-carry flag |
| upd_c | input | 1 | Instruction updates the carry flag |
| alu_z | input | 1 | Zero result from the ALU |
| alu_dc | input | 1 | Digit carry from the ALU |
| alu_c | input | 1 | Carry from the ALU |
| ev_clrwdt | input | 1 | Watchdog-clear instruction executed |
| ev_sleep | input | 1 | Sleep instruction executed |
| ev_wdt_to | input | 1 | Watchdog timed out |
| psw_q | output | 8 | Current status word |
| bank_sel | output | 1 | Data bank select for direct addressing |

## Verification
The assertions check on every cycle that a timeout always leaves `TOF` low and a sleep always leaves `PDF` low. They also check that the power bits stay stable when no event is present, that a flag which is not enabled holds during a masked write, and that the bank bits follow an unmasked write. Other behaviour shows only in the bench's scenarios, which compare against a behavioural model: the exact clear-file pattern, the priority between simultaneous events, and long mixed sequences of writes, flag updates and events.

// File: rtl/psw_pkg.sv
package psw_pkg;
   localparam int PSW_W   = 8;
   localparam int NFLAG   = 3;
   localparam int B_IRB   = 7;
   localparam int B_BKH   = 6;
   localparam int B_BKL   = 5;
   localparam int B_TOF   = 4;
   localparam int B_PDF   = 3;
   localparam int B_ZF    = 2;
   localparam int B_DCF   = 1;
   localparam int B_CF    = 0;

   typedef struct packed {
      logic clrwdt;
      logic sleep;
      logic wdt_to;
   } pwr_ev_t;
endpackage

// File: rtl/psw_flag_bit.sv
module psw_flag_bit #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_bit,
   input  logic any_upd,
   input  logic upd,
   input  logic alu_bit,
   output logic q
);
   logic nxt;

   always_comb begin
      nxt = q;
      if (upd)
         nxt = alu_bit;
      else if (wr_en && !any_upd)
         nxt = wr_bit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= nxt;
   end

   AST_FLAG_MASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && any_upd && !upd) |=> $stable(q)); // R4

   AST_FLAG_TAKES_ALU: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> (q == $past(alu_bit))); // R5
endmodule

// File: rtl/psw_power_bits.sv
module psw_power_bits
   import psw_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  pwr_ev_t ev,
   output logic    to_q,
   output logic    pd_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         to_q <= 1'b1;
         pd_q <= 1'b1;
      end else begin
         if (ev.wdt_to)
            to_q <= 1'b0;
         else if (ev.clrwdt || ev.sleep)
            to_q <= 1'b1;
         if (ev.sleep)
            pd_q <= 1'b0;
         else if (ev.clrwdt)
            pd_q <= 1'b1;
      end
   end

   AST_TO_TIMEOUT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ev.wdt_to |=> !to_q); // R7

   AST_PD_SLEEP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ev.sleep |=> !pd_q); // R8

   AST_PWR_NO_EVENT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev.wdt_to || ev.sleep || ev.clrwdt) |=> ($stable(to_q) && $stable(pd_q))); // R3
endmodule

// File: rtl/psw_bank_bits.sv
module psw_bank_bits #(
   parameter bit UPPER_EN = 1'b1,
   parameter int BANK_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BANK_W-1:0] wr_bits,
   output logic [BANK_W-1:0] q
);
   localparam int LOW_IDX = 0;

   if (BANK_W < 1) begin : g_bad_w
      $error("psw_bank_bits: BANK_W must be at least 1");
   end

   logic low_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     low_q <= 1'b0;
      else if (wr_en) low_q <= wr_bits[LOW_IDX];
   end

   if (BANK_W > 1) begin : g_upper
      logic [BANK_W-2:0] hi_q;
      if (UPPER_EN) begin : g_rw
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     hi_q <= '0;
            else if (wr_en) hi_q <= wr_bits[BANK_W-1:1];
         end
      end else begin : g_zero
         assign hi_q = '0;
      end
      assign q = {hi_q, low_q};
   end else begin : g_single
      assign q = low_q;
   end

   AST_BANK_LOW_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (q[LOW_IDX] == $past(wr_bits[LOW_IDX]))); // R9

   AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(q)); // R2
endmodule

// File: rtl/psw_ctrl.sv
module psw_ctrl
   import psw_pkg::*;
#(
   parameter bit             UPPER_BANK_EN = 1'b1,
   parameter logic [NFLAG-1:0] FLAG_RST    = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [PSW_W-1:0] wr_data,
   input  logic             upd_z,
   input  logic             upd_dc,
   input  logic             upd_c,
   input  logic             alu_z,
   input  logic             alu_dc,
   input  logic             alu_c,
   input  logic             ev_clrwdt,
   input  logic             ev_sleep,
   input  logic             ev_wdt_to,
   output logic [PSW_W-1:0] psw_q,
   output logic             bank_sel
);
   localparam int BANK_W = B_IRB - B_BKL + 1;

   if (B_TOF != B_BKL - 1 || B_PDF != B_TOF - 1 || B_ZF != NFLAG - 1) begin : g_layout_chk
      $error("psw_ctrl: status layout inconsistent");
   end

   logic [NFLAG-1:0]  upd_v, alu_v, flag_q;
   logic [BANK_W-1:0] bank_q;
   logic              any_upd, to_q, pd_q;
   pwr_ev_t           ev;

   assign upd_v   = {upd_z, upd_dc, upd_c};
   assign alu_v   = {alu_z, alu_dc, alu_c};
   assign any_upd = |upd_v;
   assign ev      = '{clrwdt: ev_clrwdt, sleep: ev_sleep, wdt_to: ev_wdt_to};

   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      psw_flag_bit #(.RST_VAL(FLAG_RST[i])) u_flag (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_en),
         .wr_bit  (wr_data[i]),
         .any_upd (any_upd),
         .upd     (upd_v[i]),
         .alu_bit (alu_v[i]),
         .q       (flag_q[i])
      );
   end

   psw_power_bits u_pwr (
      .clk   (clk),
      .rst_n (rst_n),
      .ev    (ev),
      .to_q  (to_q),
      .pd_q  (pd_q)
   );

   psw_bank_bits #(.UPPER_EN(UPPER_BANK_EN), .BANK_W(BANK_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_bits (wr_data[B_IRB:B_BKL]),
      .q       (bank_q)
   );

   assign psw_q    = {bank_q, to_q, pd_q, flag_q};
   assign bank_sel = psw_q[B_BKL];

   AST_MASKED_WRITE_BANK_STILL_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && any_upd) |=> (bank_sel == $past(wr_data[B_BKL]))); // R4
endmodule

// File: tb/psw_ctrl_bench.sv
module psw_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 0, upd_z = 0, upd_dc = 0, upd_c = 0;
   logic       alu_z = 0, alu_dc = 0, alu_c = 0;
   logic       ev_clrwdt = 0, ev_sleep = 0, ev_wdt_to = 0;
   logic [7:0] wr_data = '0;
   logic [7:0] psw_q;
   logic       bank_sel;

   int checks = 0, errors = 0, cycles = 0;
   bit done = 0;
   string cur_req = "R1", exp_req = "R1";
   logic [7:0] m = 8'h18;

   always #10 clk = ~clk;

   psw_ctrl u_psw_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .upd_z(upd_z), .upd_dc(upd_dc), .upd_c(upd_c),
      .alu_z(alu_z), .alu_dc(alu_dc), .alu_c(alu_c),
      .ev_clrwdt(ev_clrwdt), .ev_sleep(ev_sleep), .ev_wdt_to(ev_wdt_to),
      .psw_q(psw_q), .bank_sel(bank_sel)
   );

   // behavioural reference model, updated on each rising edge
   always @(posedge clk) begin
      bit masked;
      exp_req = cur_req;
      if (!rst_n) m = 8'h18;
      else begin
         masked = upd_z | upd_dc | upd_c;
         if (wr_en) begin
            m[7] = wr_data[7]; m[6] = wr_data[6]; m[5] = wr_data[5];
            if (!masked) begin
               m[2] = wr_data[2]; m[1] = wr_data[1]; m[0] = wr_data[0];
            end
         end
         if (upd_z)  m[2] = alu_z;
         if (upd_dc) m[1] = alu_dc;
         if (upd_c)  m[0] = alu_c;
         if (ev_wdt_to) m[4] = 0;
         else if (ev_clrwdt || ev_sleep) m[4] = 1;
         if (ev_sleep) m[3] = 0;
         else if (ev_clrwdt) m[3] = 1;
      end
   end

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h at cycle %0d", req, act, exp, cycles);
      end
   endtask

   // compare every cycle away from the active edge
   always @(negedge clk) begin
      cycles++;
      if (!done) begin
         chk(exp_req, psw_q, m);
         chk("R9", {7'd0, bank_sel}, {7'd0, m[5]});
      end
      if (cycles > 20000 && !done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog actual hung expected finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic idle();
      wr_en = 0; wr_data = '0; upd_z = 0; upd_dc = 0; upd_c = 0;
      alu_z = 0; alu_dc = 0; alu_c = 0;
      ev_clrwdt = 0; ev_sleep = 0; ev_wdt_to = 0;
   endtask

   task automatic cyc(string req);
      cur_req = req;
      @(negedge clk);
      idle();
   endtask

   initial begin
      idle();
      repeat (3) @(negedge clk);
      chk("R1", psw_q, 8'h18);
      rst_n = 1;
      @(negedge clk);
      chk("R1", psw_q, 8'h18);

      // R2 / R3: plain writes, power bits untouched
      wr_en = 1; wr_data = 8'hE7; cyc("R2");
      chk("R3", psw_q, 8'hFF);
      wr_en = 1; wr_data = 8'h00; cyc("R3");
      chk("R3", psw_q, 8'h18);
      wr_en = 1; wr_data = 8'h5A; cyc("R2");

      // R4: masked write
      wr_en = 1; wr_data = 8'h07; cyc("R2");
      wr_en = 1; wr_data = 8'hA0; upd_c = 1; alu_c = 0; cyc("R4");
      chk("R4", psw_q, 8'hBE);
      wr_en = 1; wr_data = 8'h07; upd_dc = 1; alu_dc = 0; cyc("R4");
      chk("R4", psw_q, 8'h1C);

      // R5: flag-only updates
      upd_z = 1; alu_z = 0; cyc("R5");
      upd_c = 1; alu_c = 1; cyc("R5");
      chk("R5", psw_q, 8'h19);

      // R6: clear-file pattern with DC and C set
      wr_en = 1; wr_data = 8'hE3; cyc("R2");
      wr_en = 1; wr_data = 8'h00; upd_z = 1; alu_z = 1; cyc("R6");
      chk("R6", psw_q, 8'h1F);

      // R7 / R8: power events
      ev_wdt_to = 1; cyc("R7");
      chk("R7", psw_q & 8'h18, 8'h08);
      ev_clrwdt = 1; cyc("R7");
      ev_sleep = 1; cyc("R8");
      chk("R8", psw_q & 8'h18, 8'h10);
      ev_wdt_to = 1; ev_clrwdt = 1; cyc("R7");
      chk("R7", psw_q & 8'h18, 8'h08);
      ev_sleep = 1; ev_clrwdt = 1; cyc("R8");
      chk("R8", psw_q & 8'h18, 8'h10);
      ev_wdt_to = 1; cyc("R8");
      wr_en = 1; wr_data = 8'hFF; cyc("R3");
      chk("R3", psw_q & 8'h18, 8'h00);

      // R9: bank select
      wr_en = 1; wr_data = 8'h20; cyc("R9");
      chk("R9", {7'd0, bank_sel}, 8'h01);
      wr_en = 1; wr_data = 8'hDF; cyc("R9");
      chk("R9", {7'd0, bank_sel}, 8'h00);

      // mixed pseudo-random traffic
      for (int i = 0; i < 400; i++) begin
         wr_en = $urandom_range(0, 1); wr_data = 8'($urandom);
         upd_z = ($urandom_range(0, 3) == 0); upd_dc = ($urandom_range(0, 3) == 0);
         upd_c = ($urandom_range(0, 3) == 0);
         alu_z = $urandom_range(0, 1); alu_dc = $urandom_range(0, 1); alu_c = $urandom_range(0, 1);
         ev_clrwdt = ($urandom_range(0, 5) == 0); ev_sleep = ($urandom_range(0, 5) == 0);
         ev_wdt_to = ($urandom_range(0, 5) == 0);
         cyc("R4");
      end

      repeat (2) @(negedge clk);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule